// File: doc/BRIEF.md
# Saturating Wiper Step and Shift Unit

This block keeps two wiper position registers of 10 bits each and changes them in response to adjustment commands. A command arrives as a one-cycle strobe that carries a 4-bit opcode, a 4-bit target address and a 10-bit data field. A command either loads one wiper directly, or steps one wiper or both wipers. The steps are plus one and minus one, which saturate at full scale and at zero. There are also two half/double steps built from one-bit shifts. The right shift rotates the old LSB into the MSB. The left shift feeds a 1 in at the LSB, so repeated use settles at all ones.

The unit remembers the last adjustment it executed. A bare repeat strobe, which is a chip-select pulse with no new frame, then applies that adjustment again to the same target. This allows push-button style control. Any command that is not a valid adjustment clears this memory. Every change shows on the outputs one clock after the strobe that caused it.

Top module: `wiper_step_unit`

## Requirements
- R1: After synchronous reset both wipers read 512 (midscale) and the repeat memory is empty, so a repeat strobe alone changes nothing.
- R2: Opcode 11 loads the 10-bit data field into the wiper picked by the address (0 selects wiper0, 1 selects wiper1), visible one clock after the strobe; the other wiper keeps its value.
- R3: Opcode 14 adds one to the addressed wiper and opcode 15 adds one to both; a wiper at 1023 stays at 1023.
- R4: Opcode 6 subtracts one from the addressed wiper and opcode 7 from both; a wiper at 0 stays at 0.
- R5: Opcode 4 (addressed wiper) and opcode 5 (both wipers) shift right by one bit, with the old bit 0 entering bit 9.
- R6: Opcode 12 (addressed wiper) and opcode 13 (both wipers) shift left by one bit with a 1 entering bit 0, so all ones stays all ones.
- R7: The step and shift opcodes (4, 5, 6, 7, 12, 13, 14, 15) ignore the data field.
- R8: After a step or shift opcode has executed, each repeat strobe without a command strobe applies the same opcode to the same target again.
- R9: Opcodes 0 to 3 and 8 to 10 leave both wipers unchanged, and these opcodes and opcode 11 all clear the repeat memory.
- R10: A single-wiper opcode whose address is neither 0 nor 1 leaves both wipers unchanged and clears the repeat memory.
- R11: When a command strobe and a repeat strobe come in the same cycle, only the new command takes effect, and it replaces the repeat memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe carrying a new command frame |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 4 | Target wiper address |
| cmd_data | input | 10 | Load value for opcode 11 |
| repeat_stb | input | 1 | Bare chip-select strobe that replays the remembered adjustment |
| wiper0 | output | 10 | Wiper 0 position |
| wiper1 | output | 10 | Wiper 1 position |

## Verification
Two functions can fall in the same cycle: a new command frame and a replay of the remembered adjustment. The bench raises both strobes on one edge. In that cycle the new frame is an opposite step on the same wiper. A lone repeat strobe follows it. The result is judged by the wiper value: it must move once, in the direction of the new frame, and the following replay must repeat the new direction, not the old one.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
    localparam int WIPER_W = 10;
    localparam int OP_W    = 4;
    localparam int ADDR_W  = 4;
    localparam int NUM_WIP = 2;

    localparam logic [WIPER_W-1:0] WIPER_MAX = {WIPER_W{1'b1}};
    localparam logic [WIPER_W-1:0] WIPER_MIN = '0;
    localparam logic [WIPER_W-1:0] WIPER_MID = {1'b1, {(WIPER_W-1){1'b0}}};

    localparam logic [OP_W-1:0] OP_SHR_ONE = 4'd4;
    localparam logic [OP_W-1:0] OP_SHR_ALL = 4'd5;
    localparam logic [OP_W-1:0] OP_DEC_ONE = 4'd6;
    localparam logic [OP_W-1:0] OP_DEC_ALL = 4'd7;
    localparam logic [OP_W-1:0] OP_LOAD    = 4'd11;
    localparam logic [OP_W-1:0] OP_SHL_ONE = 4'd12;
    localparam logic [OP_W-1:0] OP_SHL_ALL = 4'd13;
    localparam logic [OP_W-1:0] OP_INC_ONE = 4'd14;
    localparam logic [OP_W-1:0] OP_INC_ALL = 4'd15;

    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_LOAD = 3'd1,
        ACT_INC  = 3'd2,
        ACT_DEC  = 3'd3,
        ACT_SHR  = 3'd4,
        ACT_SHL  = 3'd5
    } act_e;

    typedef struct packed {
        act_e               act;
        logic [NUM_WIP-1:0] sel;
        logic               arm;
    } step_plan_t;

    function automatic logic [WIPER_W-1:0] next_wiper(
        input act_e               a,
        input logic [WIPER_W-1:0] v,
        input logic [WIPER_W-1:0] d
    );
        logic [WIPER_W-1:0] r;
        case (a)
            ACT_LOAD: r = d;
            ACT_INC:  r = (v == WIPER_MAX) ? v : v + 1'b1;
            ACT_DEC:  r = (v == WIPER_MIN) ? v : v - 1'b1;
            ACT_SHR:  r = {v[0], v[WIPER_W-1:1]};
            ACT_SHL:  r = {v[WIPER_W-2:0], 1'b1};
            default:  r = v;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/wstep_decode.sv
module wstep_decode
    import wstep_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] addr,
    output step_plan_t        plan
);
    logic               single;
    logic [NUM_WIP-1:0] addr_hit;

    always_comb begin
        for (int i = 0; i < NUM_WIP; i++) begin
            addr_hit[i] = (addr == ADDR_W'(i));
        end
    end

    always_comb begin
        plan.act = ACT_NONE;
        single   = 1'b1;
        case (op)
            OP_SHR_ONE: plan.act = ACT_SHR;
            OP_SHR_ALL: begin plan.act = ACT_SHR; single = 1'b0; end
            OP_DEC_ONE: plan.act = ACT_DEC;
            OP_DEC_ALL: begin plan.act = ACT_DEC; single = 1'b0; end
            OP_LOAD:    plan.act = ACT_LOAD;
            OP_SHL_ONE: plan.act = ACT_SHL;
            OP_SHL_ALL: begin plan.act = ACT_SHL; single = 1'b0; end
            OP_INC_ONE: plan.act = ACT_INC;
            OP_INC_ALL: begin plan.act = ACT_INC; single = 1'b0; end
            default:    plan.act = ACT_NONE;
        endcase
        if (plan.act == ACT_NONE) begin
            plan.sel = '0;
        end else if (single) begin
            plan.sel = addr_hit;
        end else begin
            plan.sel = '1;
        end
        plan.arm = (plan.act != ACT_NONE) && (plan.act != ACT_LOAD) && (plan.sel != '0);
    end
endmodule

// File: rtl/wstep_lane.sv
module wstep_lane
    import wstep_pkg::*;
#(
    parameter logic [WIPER_W-1:0] INIT = WIPER_MID
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  act_e               act,
    input  logic [WIPER_W-1:0] data,
    output logic [WIPER_W-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val <= INIT;
        end else if (en) begin
            val <= next_wiper(act, val, data);
        end
    end

    assert_inc_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
        (en && act == ACT_INC && val == WIPER_MAX) |=> (val == WIPER_MAX));

    assert_dec_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (en && act == ACT_DEC && val == WIPER_MIN) |=> (val == WIPER_MIN));

    assert_shr_rotate_R5: assert property (@(posedge clk) disable iff (rst)
        (en && act == ACT_SHR) |=> (val[WIPER_W-1] == $past(val[0])));

    assert_shl_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (en && act == ACT_SHL) |=> (val[0] == 1'b1));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(val));
endmodule

// File: rtl/wiper_step_unit.sv
module wiper_step_unit
    import wstep_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [OP_W-1:0]    cmd_op,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [WIPER_W-1:0] cmd_data,
    input  logic               repeat_stb,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1
);
    step_plan_t          dec_plan;
    step_plan_t          rep_plan;
    logic                rep_valid;
    step_plan_t          cur_plan;
    logic [WIPER_W-1:0]  wval [NUM_WIP];

    wstep_decode u_decode (
        .op   (cmd_op),
        .addr (cmd_addr),
        .plan (dec_plan)
    );

    always_comb begin
        if (cmd_valid) begin
            cur_plan = dec_plan;
        end else if (repeat_stb && rep_valid) begin
            cur_plan = rep_plan;
        end else begin
            cur_plan = '{act: ACT_NONE, sel: '0, arm: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_valid <= 1'b0;
            rep_plan  <= '{act: ACT_NONE, sel: '0, arm: 1'b0};
        end else if (cmd_valid) begin
            rep_valid <= dec_plan.arm;
            rep_plan  <= dec_plan;
        end
    end

    for (genvar g = 0; g < NUM_WIP; g++) begin : g_lane
        wstep_lane #(.INIT(WIPER_MID)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .en   (cur_plan.sel[g]),
            .act  (cur_plan.act),
            .data (cmd_data),
            .val  (wval[g])
        );
    end

    assign wiper0 = wval[0];
    assign wiper1 = wval[1];

    assert_empty_repeat_R1: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && repeat_stb && !rep_valid) |=> ($stable(wiper0) && $stable(wiper1)));

    assert_bad_target_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_addr > ADDR_W'(1) &&
         (cmd_op == OP_INC_ONE || cmd_op == OP_DEC_ONE || cmd_op == OP_SHR_ONE ||
          cmd_op == OP_SHL_ONE || cmd_op == OP_LOAD))
        |=> ($stable(wiper0) && $stable(wiper1) && !rep_valid));

    assert_frame_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && repeat_stb && cmd_op == '0) |=> ($stable(wiper0) && $stable(wiper1)));

    assert_load_disarms_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_LOAD) |=> !rep_valid);
endmodule

// File: tb/wiper_step_unit_test.sv
`timescale 1ns/1ps
module wiper_step_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [3:0] cmd_addr = '0;
    logic [9:0] cmd_data = '0;
    logic       repeat_stb = 1'b0;
    logic [9:0] wiper0;
    logic [9:0] wiper1;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wiper_step_unit uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .repeat_stb(repeat_stb),
        .wiper0(wiper0), .wiper1(wiper1)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic both(input string tag, input int e0, input int e1);
        check({tag, " wiper0"}, int'(wiper0), e0);
        check({tag, " wiper1"}, int'(wiper1), e1);
    endtask

    task automatic send(input int op, input int addr, input int data, input bit rpt = 1'b0);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = 4'(op);
        cmd_addr   = 4'(addr);
        cmd_data   = 10'(data);
        repeat_stb = rpt;
        @(negedge clk);
        cmd_valid  = 1'b0;
        repeat_stb = 1'b0;
        cmd_data   = '0;
    endtask

    task automatic rpt_only();
        @(negedge clk);
        repeat_stb = 1'b1;
        @(negedge clk);
        repeat_stb = 1'b0;
    endtask

    task automatic t_reset();
        both("R1 reset", 512, 512);
        rpt_only();
        both("R1 repeat after reset", 512, 512);
    endtask

    task automatic t_load();
        send(11, 0, 5);
        both("R2 load wiper0", 5, 512);
        send(11, 1, 1020);
        both("R2 load wiper1", 5, 1020);
    endtask

    task automatic t_inc();
        send(14, 1, 0);
        both("R3 inc one", 5, 1021);
        send(15, 0, 0);
        both("R3 inc all", 6, 1022);
        send(15, 0, 0);
        both("R3 inc all to top", 7, 1023);
        send(15, 0, 0);
        both("R3 inc all saturate", 8, 1023);
    endtask

    task automatic t_dec();
        send(11, 0, 1);
        send(6, 0, 1023);
        both("R4 R7 dec one data ignored", 0, 1023);
        send(6, 0, 0);
        both("R4 dec floor", 0, 1023);
        send(7, 0, 0);
        both("R4 dec all", 0, 1022);
    endtask

    task automatic t_shr();
        send(11, 0, 3);
        send(4, 0, 0);
        both("R5 shr one rotate", 513, 1022);
        send(11, 1, 4);
        send(5, 1, 77);
        both("R5 R7 shr all", 768, 2);
    endtask

    task automatic t_shl();
        send(11, 0, 5);
        send(11, 1, 1023);
        send(12, 0, 0);
        both("R6 shl one", 11, 1023);
        send(13, 0, 300);
        both("R6 R7 shl all, ones stays", 23, 1023);
    endtask

    task automatic t_repeat();
        send(11, 0, 10);
        send(14, 0, 0);
        both("R8 arm inc", 11, 1023);
        rpt_only();
        both("R8 repeat 1", 12, 1023);
        rpt_only();
        both("R8 repeat 2", 13, 1023);
        send(0, 0, 0);
        both("R9 nop no change", 13, 1023);
        rpt_only();
        both("R9 repeat after nop", 13, 1023);
        send(6, 0, 0);
        send(11, 0, 100);
        rpt_only();
        both("R9 repeat after load", 100, 1023);
        send(6, 0, 0);
        send(2, 0, 55);
        both("R9 op2 no change", 99, 1023);
        rpt_only();
        both("R9 repeat after op2", 99, 1023);
    endtask

    task automatic t_badaddr();
        send(6, 0, 0);
        both("R10 setup", 98, 1023);
        send(14, 3, 0);
        both("R10 bad addr inc", 98, 1023);
        rpt_only();
        both("R10 repeat cleared", 98, 1023);
        send(11, 2, 7);
        both("R10 bad addr load", 98, 1023);
    endtask

    task automatic t_collide();
        send(11, 1, 500);
        send(14, 1, 0);
        both("R11 arm inc", 98, 501);
        send(6, 1, 0, 1'b1);
        both("R11 frame wins", 98, 500);
        rpt_only();
        both("R11 new memory replays", 98, 499);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_inc();
        t_dec();
        t_shr();
        t_shl();
        t_repeat();
        t_badaddr();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule